// File: doc/BRIEF.md
# SHA-1 Single-Block MAC Engine

This block hashes one 512-bit message block with the SHA-1 compression function and returns the 160-bit result as a message authentication code. A host puts the whole block on a 512-bit bus and pulses `start`. The engine captures the block and loads the five working words with the standard SHA-1 starting values. It then runs 80 rounds at one round per clock. After the last round it adds the starting values back and raises `done` for one cycle, with the result on `mac`.

The block hashes exactly one block each time, always from the fixed starting values. There is no chaining input. Building the message block (secret, challenge, identifiers, padding) is left to the surrounding logic.

Top module: `sha1_mac`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `mac` is all zeros.
- R2: For the single padded block of the three-byte message "abc" (word 0 = 61626380h, words 1 to 14 = 0, word 15 = 00000018h), `mac` equals A9993E36 4706816A BA3E2571 7850C26C 9CD0D89D (hex).
- R3: `mac[159:128]` holds the first working word plus 67452301h. `mac[127:96]`, `mac[95:64]`, `mac[63:32]` and `mac[31:0]` hold the following words plus EFCDAB89h, 98BADCFEh, 10325476h and C3D2E1F0h. All additions are modulo 2^32.
- R4: Every round uses TMP = rol5(A) + F + E + W + K, then E=D, D=C, C=rol30(B), B=A, A=TMP. F and K follow the four 20-round groups: choose / 5A827999h, parity / 6ED9EBA1h, majority / 8F1BBCDCh, parity / CA62C1D6h. The result therefore matches a SHA-1 reference model for any block.
- R5: Message word i (i = 0..15) is taken from `msgBlock[511-32*i -: 32]`, so word 0 is the most significant 32 bits. Words 16 to 79 are rol1(W[t-3]^W[t-8]^W[t-14]^W[t-16]).
- R6: `start` is sampled on a rising edge while idle. `busy` is high from the next cycle on, and `done` rises on the 82nd rising edge, counting the edge that sampled `start`. While `done` is high, `busy` is low.
- R7: A `start` pulse while `busy` is high is ignored. Neither the result nor the completion time changes.
- R8: `done` is high for exactly one clock cycle per computation.
- R9: `mac` holds its value after `done` until the next computation completes.
- R10: `msgBlock` changes after the sampling edge have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation; sampled only while idle |
| msgBlock | input | 512 | Message block, word 0 in bits 511:480 |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse: `mac` is valid |
| mac | output | 160 | Result, A+H0 in bits 159:128 down to E+H4 in bits 31:0 |

## Verification
A wrong round function, constant, rotation or schedule tap corrupts every later round. So any internal error shows up as a complete mismatch of `mac`, seen on the cycle `done` rises. The directed blocks are chosen so that each F/K group and each schedule tap carries non-zero data. A wrong round counter or state sequence shows up as `done` rising on a different cycle than the 82nd edge, or lasting longer than one cycle. A start that is wrongly accepted while busy shows up as an early `done` or as a result from the second block.

// File: rtl/sha1_mac_pkg.sv
package sha1_mac_pkg;
  localparam int WORD_W     = 32;
  localparam int NUM_WORDS  = 16;
  localparam int NUM_ROUNDS = 80;
  localparam int GROUP_LEN  = 20;
  localparam int ROUND_W    = $clog2(NUM_ROUNDS);
  localparam int IDX_W      = $clog2(NUM_WORDS);
  localparam int BLOCK_W    = WORD_W * NUM_WORDS;
  localparam int MAC_W      = WORD_W * 5;

  localparam logic [WORD_W-1:0] INIT_A = 32'h67452301;
  localparam logic [WORD_W-1:0] INIT_B = 32'hEFCDAB89;
  localparam logic [WORD_W-1:0] INIT_C = 32'h98BADCFE;
  localparam logic [WORD_W-1:0] INIT_D = 32'h10325476;
  localparam logic [WORD_W-1:0] INIT_E = 32'hC3D2E1F0;

  localparam logic [WORD_W-1:0] KCONST_0 = 32'h5A827999;
  localparam logic [WORD_W-1:0] KCONST_1 = 32'h6ED9EBA1;
  localparam logic [WORD_W-1:0] KCONST_2 = 32'h8F1BBCDC;
  localparam logic [WORD_W-1:0] KCONST_3 = 32'hCA62C1D6;

  typedef struct packed {
    logic load;
    logic round;
    logic finish;
  } ctrlStrobes_t;

  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic logic [WORD_W-1:0] roundMix(input logic [ROUND_W-1:0] t,
                                                 input logic [WORD_W-1:0] b,
                                                 input logic [WORD_W-1:0] c,
                                                 input logic [WORD_W-1:0] d);
    if (t < ROUND_W'(GROUP_LEN))          return (b & c) | (~b & d);
    else if (t < ROUND_W'(2 * GROUP_LEN)) return b ^ c ^ d;
    else if (t < ROUND_W'(3 * GROUP_LEN)) return (b & c) | (b & d) | (c & d);
    else                                  return b ^ c ^ d;
  endfunction

  function automatic logic [WORD_W-1:0] roundConst(input logic [ROUND_W-1:0] t);
    if (t < ROUND_W'(GROUP_LEN))          return KCONST_0;
    else if (t < ROUND_W'(2 * GROUP_LEN)) return KCONST_1;
    else if (t < ROUND_W'(3 * GROUP_LEN)) return KCONST_2;
    else                                  return KCONST_3;
  endfunction
endpackage

// File: rtl/sha1_mac_ctrl.sv
module sha1_mac_ctrl
  import sha1_mac_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output ctrlStrobes_t       strobes,
  output logic [ROUND_W-1:0] roundIdx,
  output logic               busy,
  output logic               done
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FINISH} ctrlState_t;

  localparam logic [ROUND_W-1:0] LAST_ROUND = ROUND_W'(NUM_ROUNDS - 1);

  ctrlState_t          state;
  logic [ROUND_W-1:0]  roundCnt;
  logic                doneQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      roundCnt <= '0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= (state == S_FINISH);
      unique case (state)
        S_IDLE: begin
          if (start) begin
            state    <= S_RUN;
            roundCnt <= '0;
          end
        end
        S_RUN: begin
          roundCnt <= roundCnt + 1'b1;
          if (roundCnt == LAST_ROUND) state <= S_FINISH;
        end
        S_FINISH: state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.load   = (state == S_IDLE) && start;
    strobes.round  = (state == S_RUN);
    strobes.finish = (state == S_FINISH);
  end

  assign roundIdx = roundCnt;
  assign busy     = (state != S_IDLE);
  assign done     = doneQ;

  p_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && roundCnt == '0));
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && roundCnt != LAST_ROUND && start) |=>
      (state == S_RUN && roundCnt == $past(roundCnt) + 1'b1));
endmodule

// File: rtl/sha1_mac_datapath.sv
module sha1_mac_datapath
  import sha1_mac_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStrobes_t       strobes,
  input  logic [ROUND_W-1:0] roundIdx,
  input  logic [BLOCK_W-1:0] msgBlock,
  output logic [MAC_W-1:0]   mac
);
  logic [WORD_W-1:0] regA, regB, regC, regD, regE;
  logic [WORD_W-1:0] sched [NUM_WORDS];
  logic [MAC_W-1:0]  macQ;

  logic [IDX_W-1:0]  slot;
  logic [WORD_W-1:0] expanded, wordT, tmpSum;

  always_comb begin
    slot     = roundIdx[IDX_W-1:0];
    expanded = rotl(sched[slot + IDX_W'(13)] ^ sched[slot + IDX_W'(8)] ^
                    sched[slot + IDX_W'(2)]  ^ sched[slot], 1);
    wordT    = (roundIdx < ROUND_W'(NUM_WORDS)) ? sched[slot] : expanded;
    tmpSum   = rotl(regA, 5) + roundMix(roundIdx, regB, regC, regD) + regE
               + wordT + roundConst(roundIdx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regA <= '0; regB <= '0; regC <= '0; regD <= '0; regE <= '0;
      macQ <= '0;
      for (int i = 0; i < NUM_WORDS; i++) sched[i] <= '0;
    end else if (strobes.load) begin
      regA <= INIT_A; regB <= INIT_B; regC <= INIT_C; regD <= INIT_D; regE <= INIT_E;
      for (int i = 0; i < NUM_WORDS; i++)
        sched[i] <= msgBlock[BLOCK_W-1-WORD_W*i -: WORD_W];
    end else if (strobes.round) begin
      regE <= regD;
      regD <= regC;
      regC <= rotl(regB, 30);
      regB <= regA;
      regA <= tmpSum;
      sched[slot] <= wordT;
    end else if (strobes.finish) begin
      macQ <= {regA + INIT_A, regB + INIT_B, regC + INIT_C, regD + INIT_D, regE + INIT_E};
    end
  end

  assign mac = macQ;

  p_mac_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.finish |=> $stable(macQ));
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.load, strobes.round, strobes.finish}));
endmodule

// File: rtl/sha1_mac.sv
module sha1_mac
  import sha1_mac_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [511:0]   msgBlock,
  output logic           busy,
  output logic           done,
  output logic [159:0]   mac
);
  ctrlStrobes_t       strobes;
  logic [ROUND_W-1:0] roundIdx;

  sha1_mac_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .strobes  (strobes),
    .roundIdx (roundIdx),
    .busy     (busy),
    .done     (done)
  );

  sha1_mac_datapath u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .roundIdx (roundIdx),
    .msgBlock (msgBlock),
    .mac      (mac)
  );
endmodule

// File: tb/sha1_mac_test.sv
module sha1_mac_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [511:0] msgBlock = '0;
  logic         busy, done;
  logic [159:0] mac;

  int checks = 0;
  int errors = 0;

  sha1_mac uut (.clk(clk), .rst_n(rst_n), .start(start), .msgBlock(msgBlock),
                .busy(busy), .done(done), .mac(mac));

  always #2 clk = ~clk;

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [159:0] refMac(input logic [511:0] blk);
    logic [31:0] w [80];
    logic [31:0] a, b, c, d, e, f, k, t2;
    for (int t = 0; t < 16; t++) w[t] = blk[511-32*t -: 32];
    for (int t = 16; t < 80; t++) w[t] = rl(w[t-3] ^ w[t-8] ^ w[t-14] ^ w[t-16], 1);
    a = 32'h67452301; b = 32'hEFCDAB89; c = 32'h98BADCFE; d = 32'h10325476; e = 32'hC3D2E1F0;
    for (int t = 0; t < 80; t++) begin
      if (t < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
      else if (t < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
      else if (t < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
      else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
      t2 = rl(a, 5) + f + e + w[t] + k;
      e = d; d = c; c = rl(b, 30); b = a; a = t2;
    end
    return {a + 32'h67452301, b + 32'hEFCDAB89, c + 32'h98BADCFE,
            d + 32'h10325476, e + 32'hC3D2E1F0};
  endfunction

  task automatic check(input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Pulses start with blk, returns edges to done (counting the sampling edge).
  task automatic launch(input logic [511:0] blk, output int edges);
    @(negedge clk);
    start = 1'b1; msgBlock = blk;
    @(negedge clk);
    start = 1'b0;
    edges = 1;
    while (!done && edges < 300) begin
      @(negedge clk);
      edges++;
    end
  endtask

  task automatic testReset();
    check("R1 busy", {159'd0, busy}, 160'd0);
    check("R1 done", {159'd0, done}, 160'd0);
    check("R1 mac", mac, 160'd0);
  endtask

  task automatic testKnownVector();
    logic [511:0] blk;
    int edges;
    blk = '0;
    blk[511:480] = 32'h61626380;
    blk[31:0]    = 32'h00000018;
    launch(blk, edges);
    check("R2 abc vector", mac, 160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D);
    check("R3 top word A+H0", {128'd0, mac[159:128]}, {128'd0, 32'hA9993E36});
    check("R6 latency", 160'(edges), 160'd82);
    check("R6 busy low at done", {159'd0, busy}, 160'd0);
    @(negedge clk);
    check("R8 done one cycle", {159'd0, done}, 160'd0);
  endtask

  task automatic testPatterns();
    logic [511:0] blk;
    int edges;
    launch('0, edges);
    check("R4 zero block", mac, refMac('0));
    launch({512{1'b1}}, edges);
    check("R4 ones block", mac, refMac({512{1'b1}}));
    for (int i = 0; i < 16; i++) blk[511-32*i -: 32] = 32'h9E3779B9 * (i + 1) ^ 32'h0F1E2D3C;
    launch(blk, edges);
    check("R4 mixed block", mac, refMac(blk));
    blk = {16{32'hA5A5_5A5A}};
    launch(blk, edges);
    check("R4 alternating block", mac, refMac(blk));
  endtask

  task automatic testWordOrder();
    logic [511:0] blk;
    int edges;
    blk = '0; blk[511:480] = 32'h00000001;
    launch(blk, edges);
    check("R5 word0 only", mac, refMac(blk));
    blk = '0; blk[31:0] = 32'h80000000;
    launch(blk, edges);
    check("R5 word15 only", mac, refMac(blk));
    blk = '0; blk[511-32*7 -: 32] = 32'hDEADBEEF;
    launch(blk, edges);
    check("R5 word7 only", mac, refMac(blk));
  endtask

  task automatic testBusyStart();
    logic [511:0] blkA, blkB;
    int edges;
    blkA = {16{32'h12345678}};
    blkB = {16{32'hCAFEF00D}};
    @(negedge clk);
    start = 1'b1; msgBlock = blkA;
    @(negedge clk);
    start = 1'b0;
    check("R6 busy after start", {159'd0, busy}, 160'd1);
    edges = 1;
    for (int i = 0; i < 9; i++) begin @(negedge clk); edges++; end
    start = 1'b1; msgBlock = blkB;
    @(negedge clk); edges++;
    start = 1'b0;
    while (!done && edges < 300) begin @(negedge clk); edges++; end
    check("R7 result ignores busy start", mac, refMac(blkA));
    check("R7 latency unchanged", 160'(edges), 160'd82);
  endtask

  task automatic testInputChange();
    logic [511:0] blk;
    int edges;
    blk = {8{64'h0123_4567_89AB_CDEF}};
    @(negedge clk);
    start = 1'b1; msgBlock = blk;
    @(negedge clk);
    start = 1'b0; msgBlock = ~blk;
    edges = 1;
    while (!done && edges < 300) begin @(negedge clk); edges++; end
    check("R10 input change ignored", mac, refMac(blk));
  endtask

  task automatic testHold();
    logic [159:0] held;
    logic [511:0] blk;
    held = mac;
    for (int i = 0; i < 5; i++) @(negedge clk);
    check("R9 mac held idle", mac, held);
    blk = {16{32'h0BADF00D}};
    @(negedge clk);
    start = 1'b1; msgBlock = blk;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 40; i++) @(negedge clk);
    check("R9 mac held during run", mac, held);
    while (!done) @(negedge clk);
    check("R9 new result at done", mac, refMac(blk));
  endtask

  task automatic testBackToBack();
    logic [511:0] blk;
    int edges;
    blk = {16{32'h31415926}};
    // done is high now (idle); launch begins at the next negedge
    launch(blk, edges);
    check("R6 back-to-back latency", 160'(edges), 160'd82);
    check("R4 back-to-back result", mac, refMac(blk));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testKnownVector();
    testPatterns();
    testWordOrder();
    testBusyStart();
    testInputChange();
    testHold();
    testBackToBack();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule